// File: doc/BRIEF.md
# Timer Input Capture Unit

This block keeps a free-running binary counter and copies its value into a capture register when a trigger arrives. There are two kinds of trigger. One is an edge on one of four external interrupt lines. The other is a write strobe to the capture register from software, and the data written has no effect. A 2-bit select picks the line. A mode bit chooses between capture on a single edge and capture on both edges. In single-edge mode, a polarity bit for each line picks rising or falling.

Each line passes through a synchronizer and an edge detector in the capture clock domain. A parameter sets which clock input drives that domain: the oscillator clock when the timer runs from it, otherwise the system clock. Some lines can also raise interrupts on both edges, and each of those has its own enable. While that enable is set, a hardware edge on the line is refused: the block gives a one-cycle blocked pulse and takes no capture. A sticky capture flag and an overrun bit report captures to software.

Top module: `capture_unit`

## Requirements
- R1: A cycle with `capWr` high loads `capValue` at the next clock edge with the `count` value held during that cycle.
- R2: `srcSel` picks the trigger line: 0 selects `irqIn[0]`, 1 selects `irqIn[1]`, 2 selects `irqIn[2]`, 3 selects `irqIn[3]`.
- R3: With `singleEdge` = 1, only one edge of the selected line captures. `edgePol[n]` = 1 selects rising and `edgePol[n]` = 0 selects falling.
- R4: With `singleEdge` = 0, both rising and falling edges of the selected line capture.
- R5: A level change on `irqIn` that is first sampled at capture clock edge k loads `capValue` at edge k+2 with the `count` held between edges k+1 and k+2.
- R6: While the selected line is 2 or 3 and its bit in `dualIrqEn` is 1, a qualifying edge causes no capture and pulses `capBlocked` for one cycle at edge k+2. Bits 0 and 1 of `dualIrqEn` have no effect. A software write still captures.
- R7: When a hardware edge and `capWr` fall in the same cycle, exactly one capture takes place, with that cycle's `count`.
- R8: `capFlag` goes to 1 on every capture and stays set until a `flagClr` pulse. A capture in the same cycle as `flagClr` leaves the flag set.
- R9: `overrun` goes to 1 when a capture happens while `capFlag` is already 1. It stays set until a `flagClr` pulse with no overrunning capture in that cycle.
- R10: Reset sets `count`, `capValue`, `capFlag`, `overrun` and `capBlocked` to zero. `count` rises by one in each cycle with `cntEn` high, holds when `cntEn` is low, and wraps from 0xFFFF to 0x0000.
- R11: Edges on lines that are not selected cause no capture and no blocked pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oscClk | input | 1 | Oscillator clock, used as the capture clock when the timer runs from it |
| sysClk | input | 1 | System clock, used as the capture clock otherwise |
| rstN | input | 1 | Active-low asynchronous reset |
| cntEn | input | 1 | Counter advance enable |
| irqIn | input | 4 | External interrupt lines, asynchronous |
| srcSel | input | 2 | Trigger line select |
| singleEdge | input | 1 | 1: single-edge capture, 0: both edges |
| edgePol | input | 4 | Per-line edge polarity in single-edge mode, 1 rising |
| dualIrqEn | input | 4 | Both-edge interrupt enables; only bits 2 and 3 are honoured |
| capWr | input | 1 | Software write strobe to the capture register |
| flagClr | input | 1 | Write-one-to-clear strobe for flag and overrun |
| count | output | 16 | Free-running counter value |
| capValue | output | 16 | Capture register |
| capFlag | output | 1 | Sticky capture event flag |
| overrun | output | 1 | A capture occurred while the flag was set |
| capBlocked | output | 1 | One-cycle pulse for a refused hardware capture |

## Verification
The hardest case to reach is a hardware edge and a software write landing in the same cycle. The edge only turns into a trigger two capture clocks after the line changes. The stimulus therefore raises the line and then drives `capWr` exactly two negative edges later, so that both triggers fall in one cycle. A second hard case is the counter wrap. It needs a run of more than 65,536 enabled cycles, and the bench places that run at the end so the compare covers the 0xFFFF to 0x0000 step.

// File: rtl/capture_pkg.sv
package capture_pkg;
  // Strobes from the trigger control to the datapath, valid for one cycle.
  typedef struct packed {
    logic capture;  // load the capture register this cycle
    logic blocked;  // a qualifying edge was refused
  } capStrobe_t;
endpackage

// File: rtl/cap_edge_sync.sv
module cap_edge_sync #(
  parameter int NUM_LINES   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] lineIn,
  output logic [NUM_LINES-1:0] riseP,
  output logic [NUM_LINES-1:0] fallP
);
  localparam int LAST = SYNC_STAGES - 1;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   prevQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= '0;
        prevQ <= 1'b0;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn[g]};
        prevQ <= syncQ[LAST];
      end
    end

    assign riseP[g] =  syncQ[LAST] & ~prevQ;
    assign fallP[g] = ~syncQ[LAST] &  prevQ;
  end
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import capture_pkg::*;
#(
  parameter int             NUM_LINES = 4,
  parameter logic [NUM_LINES-1:0] DUAL_MASK = 4'b1100,
  localparam int            SEL_W     = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] riseP,
  input  logic [NUM_LINES-1:0] fallP,
  input  logic [SEL_W-1:0]     srcSel,
  input  logic                 singleEdge,
  input  logic [NUM_LINES-1:0] edgePol,
  input  logic [NUM_LINES-1:0] dualIrqEn,
  input  logic                 capWr,
  output capStrobe_t           strobe
);
  logic selRise, selFall, selPol, hwHit, lineBlocked;

  always_comb begin
    selRise     = riseP[srcSel];
    selFall     = fallP[srcSel];
    selPol      = edgePol[srcSel];
    lineBlocked = DUAL_MASK[srcSel] & dualIrqEn[srcSel];
    if (singleEdge) hwHit = selPol ? selRise : selFall;
    else            hwHit = selRise | selFall;
    strobe.capture = (hwHit & ~lineBlocked) | capWr;
    strobe.blocked = hwHit & lineBlocked;
  end
endmodule

// File: rtl/cap_datapath.sv
module cap_datapath
  import capture_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEn,
  input  capStrobe_t       strobe,
  input  logic             flagClr,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capValue,
  output logic             capFlag,
  output logic             overrun,
  output logic             capBlocked
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count      <= '0;
      capValue   <= '0;
      capFlag    <= 1'b0;
      overrun    <= 1'b0;
      capBlocked <= 1'b0;
    end else begin
      if (cntEn) count <= count + 1'b1;
      if (strobe.capture) capValue <= count;
      capBlocked <= strobe.blocked;
      if (strobe.capture)   capFlag <= 1'b1;
      else if (flagClr)     capFlag <= 1'b0;
      if (strobe.capture && capFlag) overrun <= 1'b1;
      else if (flagClr)              overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/capture_unit.sv
module capture_unit
  import capture_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int NUM_LINES    = 4,
  parameter int SYNC_STAGES  = 2,
  parameter bit TIMER_ON_OSC = 1'b1,
  localparam int SEL_W       = $clog2(NUM_LINES)
) (
  input  logic                 oscClk,
  input  logic                 sysClk,
  input  logic                 rstN,
  input  logic                 cntEn,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic [SEL_W-1:0]     srcSel,
  input  logic                 singleEdge,
  input  logic [NUM_LINES-1:0] edgePol,
  input  logic [NUM_LINES-1:0] dualIrqEn,
  input  logic                 capWr,
  input  logic                 flagClr,
  output logic [CNT_W-1:0]     count,
  output logic [CNT_W-1:0]     capValue,
  output logic                 capFlag,
  output logic                 overrun,
  output logic                 capBlocked
);
  logic                 capClk;
  logic [NUM_LINES-1:0] riseP, fallP;
  capStrobe_t           strobe;

  assign capClk = TIMER_ON_OSC ? oscClk : sysClk;

  cap_edge_sync #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(capClk), .rstN(rstN), .lineIn(irqIn), .riseP(riseP), .fallP(fallP)
  );

  cap_ctrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .riseP(riseP), .fallP(fallP), .srcSel(srcSel), .singleEdge(singleEdge),
    .edgePol(edgePol), .dualIrqEn(dualIrqEn), .capWr(capWr), .strobe(strobe)
  );

  cap_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(capClk), .rstN(rstN), .cntEn(cntEn), .strobe(strobe), .flagClr(flagClr),
    .count(count), .capValue(capValue), .capFlag(capFlag), .overrun(overrun),
    .capBlocked(capBlocked)
  );
endmodule

// File: rtl/capture_unit_chk.sv
module capture_unit_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntEn,
  input logic             capWr,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] capValue,
  input logic             capFlag,
  input logic             overrun,
  input logic             capBlocked
);
  p_sw_capture_r1: assert property (@(posedge clk) disable iff (!rstN)
    capWr |=> capValue == $past(count));

  p_blocked_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (capBlocked && !$past(capWr)) |-> $stable(capValue));

  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    capWr |=> capFlag);

  p_overrun_r9: assert property (@(posedge clk) disable iff (!rstN)
    (capWr && capFlag) |=> overrun);

  p_count_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    cntEn |=> count == $past(count) + 1'b1);

  p_count_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn |=> $stable(count));
endmodule

bind capture_unit capture_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(capClk), .rstN(rstN), .cntEn(cntEn), .capWr(capWr), .count(count),
  .capValue(capValue), .capFlag(capFlag), .overrun(overrun), .capBlocked(capBlocked)
);

// File: tb/capture_unit_bench.sv
module capture_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntEn = 1'b0;
  logic [3:0]  irqIn = 4'b0;
  logic [1:0]  srcSel = 2'd0;
  logic        singleEdge = 1'b1;
  logic [3:0]  edgePol = 4'b1111;
  logic [3:0]  dualIrqEn = 4'b0;
  logic        capWr = 1'b0;
  logic        flagClr = 1'b0;
  logic [15:0] count, capValue;
  logic        capFlag, overrun, capBlocked;

  int    nCmp = 0, nBad = 0;
  string curReq = "R10";
  bit    done = 1'b0;

  always #5 clk = ~clk;

  capture_unit u_capture_unit (
    .oscClk(clk), .sysClk(1'b0), .rstN(rstN), .cntEn(cntEn), .irqIn(irqIn),
    .srcSel(srcSel), .singleEdge(singleEdge), .edgePol(edgePol),
    .dualIrqEn(dualIrqEn), .capWr(capWr), .flagClr(flagClr), .count(count),
    .capValue(capValue), .capFlag(capFlag), .overrun(overrun),
    .capBlocked(capBlocked)
  );

  // Behavioural reference: history queue of line samples, integer counter.
  int        mCount = 0, mCap = 0;
  bit        mFlag = 0, mOvr = 0, mBlk = 0;
  bit [3:0]  hist[$];

  always @(posedge clk) begin
    if (!rstN) begin
      mCount = 0; mCap = 0; mFlag = 0; mOvr = 0; mBlk = 0;
      hist = {4'b0, 4'b0, 4'b0};
    end else begin
      // hist[0] newest sample, hist[1] synchronized, hist[2] previous
      bit [3:0] nowV, oldV;
      bit hit, blockLine, cap, r, f;
      nowV = hist[1]; oldV = hist[2];
      r = nowV[srcSel] && !oldV[srcSel];
      f = !nowV[srcSel] && oldV[srcSel];
      hit = singleEdge ? (edgePol[srcSel] ? r : f) : (r || f);
      blockLine = (srcSel >= 2) && dualIrqEn[srcSel];
      cap = (hit && !blockLine) || capWr;
      mBlk = hit && blockLine;
      if (cap) mCap = mCount;
      if (cap && mFlag) mOvr = 1; else if (flagClr) mOvr = 0;
      if (cap) mFlag = 1; else if (flagClr) mFlag = 0;
      if (cntEn) mCount = (mCount + 1) % 65536;
      hist.push_front(irqIn);
      void'(hist.pop_back());
    end
  end

  task automatic cmp(string what, string req, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      cmp("count",      "R10",  count,      mCount);
      cmp("capValue",   curReq, capValue,   mCap);
      cmp("capFlag",    "R8",   capFlag,    mFlag);
      cmp("overrun",    "R9",   overrun,    mOvr);
      cmp("capBlocked", "R6",   capBlocked, mBlk);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggleLine(int ln);
    irqIn[ln] = 1'b1; tick(5);
    irqIn[ln] = 1'b0; tick(5);
  endtask

  task automatic clearFlags();
    flagClr = 1'b1; tick(1); flagClr = 1'b0; tick(1);
  endtask

  initial begin
    tick(3);
    // R10: reset values
    cmp("count reset",    "R10", count, 0);
    cmp("capValue reset", "R10", capValue, 0);
    cmp("flags reset",    "R10", {capFlag, overrun, capBlocked}, 0);
    rstN = 1'b1;
    cntEn = 1'b1;
    tick(7);

    curReq = "R1";
    capWr = 1'b1; tick(1); capWr = 1'b0; tick(3);
    clearFlags();

    // R2/R3 rising on each selected line; other lines toggled too (R11)
    curReq = "R2";
    for (int s = 0; s < 4; s++) begin
      srcSel = s[1:0];
      toggleLine(s);
      clearFlags();
      curReq = "R11";
      toggleLine((s + 1) % 4);
      curReq = "R2";
    end
    curReq = "R3";
    edgePol = 4'b0000;
    for (int s = 0; s < 4; s++) begin
      srcSel = s[1:0]; toggleLine(s); clearFlags();
    end
    edgePol = 4'b0101;
    for (int s = 0; s < 4; s++) begin
      srcSel = s[1:0]; toggleLine(s); clearFlags();
    end

    curReq = "R4";
    singleEdge = 1'b0;
    for (int s = 0; s < 4; s++) begin
      srcSel = s[1:0]; toggleLine(s);
    end
    clearFlags();

    curReq = "R5";
    cntEn = 1'b0; tick(2); cntEn = 1'b1;
    srcSel = 2'd1; irqIn[1] = 1'b1; tick(1); cntEn = 1'b0; tick(4);
    cntEn = 1'b1; irqIn[1] = 1'b0; tick(4);
    clearFlags();

    curReq = "R6";
    dualIrqEn = 4'b1111;
    for (int s = 0; s < 4; s++) begin
      srcSel = s[1:0]; toggleLine(s);
    end
    srcSel = 2'd3; irqIn[3] = 1'b1; tick(2); capWr = 1'b1; tick(1); capWr = 1'b0;
    tick(4); irqIn[3] = 1'b0; tick(4);
    dualIrqEn = 4'b0000;
    clearFlags();

    curReq = "R7";
    srcSel = 2'd2; irqIn[2] = 1'b1; tick(2); capWr = 1'b1; tick(1); capWr = 1'b0;
    tick(4);
    irqIn[2] = 1'b0; tick(4);
    clearFlags();

    curReq = "R8";
    capWr = 1'b1; tick(1); capWr = 1'b0; tick(2);
    capWr = 1'b1; flagClr = 1'b1; tick(1); capWr = 1'b0; flagClr = 1'b0; tick(2);
    clearFlags();

    curReq = "R9";
    capWr = 1'b1; tick(1); capWr = 1'b0; tick(2);
    srcSel = 2'd0; toggleLine(0);
    clearFlags();
    tick(2);

    curReq = "R10";
    cntEn = 1'b0; tick(5); cntEn = 1'b1;
    tick(65600);
    capWr = 1'b1; tick(1); capWr = 1'b0; tick(3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nCmp++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule